// File: doc/BRIEF.md
# In-band XON/XOFF receive flow controller

This block sits beside a UART receiver. Each time the receiver finishes a character it raises a one-cycle strobe. The block compares that character with four programmable codes: two resume codes and two pause codes. When a pause code matches, the block closes the transmit gate. The gate closes only after the character that is being shifted out has finished. When a resume code matches, the gate opens again. A two-bit mode field selects which codes take part: the first pair, the second pair, or either pair.

Pause and resume characters that the flow logic consumes are not forwarded to the receive data path. Every other character is forwarded one cycle after its strobe, together with its value. A separate special-character option, active only in enhanced mode, watches for the second pause code. When that code arrives, the character is still forwarded, and a sticky interrupt is raised if its enable is set. Flow control works only in enhanced mode and outside 9-bit character mode. It also requires a supported mode combination.

Top module: `xonoff_rx_flow`

## Requirements
- R1: After reset `tx_enable` is 1, `spec_irq` is 0 and `rx_push` is 0.
- R2: With `rx_fc_mode`=2'b10, a character equal to `xoff1_char` closes the gate. A character equal to `xon1_char` reopens it. The second-pair codes have no effect on the gate in this mode.
- R3: With `rx_fc_mode`=2'b01, only `xoff2_char` and `xon2_char` act as pause and resume codes. The first-pair codes have no effect on the gate in this mode.
- R4: With `rx_fc_mode`=2'b11 and `tx_fc_mode` equal to 2'b01 or 2'b10, either pause code closes the gate and either resume code reopens it.
- R5: With `rx_fc_mode`=2'b11 and `tx_fc_mode`=2'b00, the setting is unsupported and is treated as disabled. Pause codes have no effect and are forwarded as data.
- R6: While `enh_en` is 0 all mode inputs are ignored and `tx_enable` is 1 from the next cycle on.
- R7: While `nine_bit` is 1 flow control is off and `tx_enable` is 1 from the next cycle on.
- R8: After a pause match the gate stays open for as long as `tx_busy` is 1. It closes on the clock edge at which `tx_busy` is sampled as 0, which is one cycle after the match at the earliest.
- R9: A character consumed as a pause or resume code is not pushed. Any other character pulses `rx_push` for one cycle after its strobe, with `rx_push_data` equal to the character. A character that matches nothing leaves the gate state unchanged, and `rx_push` is 0 when no strobe was present.
- R10: Setting `rx_fc_mode` to 2'b00 clears the pause state. `tx_enable` is then 1 on the next cycle, and it stays 1 when the mode is enabled again.
- R11: With `enh_en`=1 and `spec_det_en`=1, a character equal to `xoff2_char` is pushed as data. If `spec_irq_en` is 1 it also sets `spec_irq`, which stays set until `spec_irq_ack` is pulsed.
- R12: With `spec_irq_en`=0 a special character is still pushed but does not set `spec_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is complete |
| rx_char | input | CHAR_W | Received character |
| enh_en | input | 1 | Enhanced-mode enable |
| rx_fc_mode | input | 2 | Receive flow mode: 00 off, 01 second pair, 10 first pair, 11 either |
| tx_fc_mode | input | 2 | Transmit flow mode field, used to qualify mode 11 |
| spec_det_en | input | 1 | Special-character detection enable |
| nine_bit | input | 1 | 9-bit character mode |
| spec_irq_en | input | 1 | Special-character interrupt enable |
| spec_irq_ack | input | 1 | Clears the pending special-character interrupt |
| xon1_char | input | CHAR_W | First resume code |
| xon2_char | input | CHAR_W | Second resume code |
| xoff1_char | input | CHAR_W | First pause code |
| xoff2_char | input | CHAR_W | Second pause code, also the special character |
| tx_busy | input | 1 | Transmitter is shifting out a character |
| tx_enable | output | 1 | Transmit gate, 1 lets the transmitter start a character |
| spec_irq | output | 1 | Special-character interrupt request |
| rx_push | output | 1 | Write strobe toward the receive FIFO |
| rx_push_data | output | CHAR_W | Character written with `rx_push` |

## Verification
The assertions check several properties on every cycle. The gate never closes while a character is in flight. It is open whenever enhanced mode is off, 9-bit mode is on or the mode field is off. Nothing is pushed without a strobe. The interrupt neither appears without an enabled special match nor clears without an acknowledge. Only the bench's scenarios can show that the right code pair is selected for each mode, and that the unsupported mode 11 setting falls back to disabled. The scenarios also show that consumed codes are held back from the data path while ordinary characters pass, and that a character matching nothing leaves the pause state untouched.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
  localparam logic [1:0] RXM_OFF  = 2'b00;
  localparam logic [1:0] RXM_SET2 = 2'b01;
  localparam logic [1:0] RXM_SET1 = 2'b10;
  localparam logic [1:0] RXM_ANY  = 2'b11;
  localparam logic [1:0] TXM_OFF  = 2'b00;

  localparam int NUM_CMP   = 4;
  localparam int IDX_XON1  = 0;
  localparam int IDX_XON2  = 1;
  localparam int IDX_XOFF1 = 2;
  localparam int IDX_XOFF2 = 3;

  typedef struct packed {
    logic xon;
    logic xoff;
    logic spec;
  } hit_t;
endpackage

// File: rtl/xfc_rst_sync.sv
module xfc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/xfc_mode_decode.sv
module xfc_mode_decode
  import xfc_pkg::*;
(
  input  logic       enh_en,
  input  logic [1:0] rx_fc_mode,
  input  logic [1:0] tx_fc_mode,
  input  logic       nine_bit,
  input  logic       spec_det_en,
  output logic       fc_active,
  output logic       use_set1,
  output logic       use_set2,
  output logic       spec_active
);
  logic mode_ok;

  always_comb begin
    // mode 11 needs a transmit mode alongside it; otherwise it is unsupported
    mode_ok     = (rx_fc_mode != RXM_OFF) &&
                  !((rx_fc_mode == RXM_ANY) && (tx_fc_mode == TXM_OFF));
    fc_active   = enh_en && !nine_bit && mode_ok;
    use_set1    = fc_active && ((rx_fc_mode == RXM_SET1) || (rx_fc_mode == RXM_ANY));
    use_set2    = fc_active && ((rx_fc_mode == RXM_SET2) || (rx_fc_mode == RXM_ANY));
    spec_active = enh_en && spec_det_en;
  end
endmodule

// File: rtl/xfc_char_match.sv
module xfc_char_match
  import xfc_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic [CHAR_W-1:0]              rx_char,
  input  logic [NUM_CMP-1:0][CHAR_W-1:0] cmp_chars,
  input  logic                           use_set1,
  input  logic                           use_set2,
  input  logic                           spec_active,
  output hit_t                           hit
);
  logic [NUM_CMP-1:0] eq;

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    assign eq[g] = (rx_char == cmp_chars[g]);
  end

  always_comb begin
    hit.xon  = (use_set1 && eq[IDX_XON1])  || (use_set2 && eq[IDX_XON2]);
    hit.xoff = (use_set1 && eq[IDX_XOFF1]) || (use_set2 && eq[IDX_XOFF2]);
    hit.spec = spec_active && eq[IDX_XOFF2];
  end
endmodule

// File: rtl/xfc_tx_gate.sv
module xfc_tx_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic char_stb,
  input  logic fc_active,
  input  logic xon_hit,
  input  logic xoff_hit,
  input  logic tx_busy,
  output logic tx_enable
);
  logic paused_q, paused_d, paused_ce;
  logic gate_q, gate_d;

  always_comb begin
    paused_ce = !fc_active || char_stb;
    paused_d  = paused_q;
    if (!fc_active)    paused_d = 1'b0;
    else if (xoff_hit) paused_d = 1'b1;
    else if (xon_hit)  paused_d = 1'b0;
  end

  always_comb begin
    gate_d = gate_q;
    if (!fc_active || !paused_q) gate_d = 1'b1;
    else if (!tx_busy)           gate_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paused_q <= 1'b0;
      gate_q   <= 1'b1;
    end else begin
      if (paused_ce) paused_q <= paused_d;
      gate_q <= gate_d;
    end
  end

  assign tx_enable = gate_q;
endmodule

// File: rtl/xonoff_rx_flow.sv
module xonoff_rx_flow
  import xfc_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              enh_en,
  input  logic [1:0]        rx_fc_mode,
  input  logic [1:0]        tx_fc_mode,
  input  logic              spec_det_en,
  input  logic              nine_bit,
  input  logic              spec_irq_en,
  input  logic              spec_irq_ack,
  input  logic [CHAR_W-1:0] xon1_char,
  input  logic [CHAR_W-1:0] xon2_char,
  input  logic [CHAR_W-1:0] xoff1_char,
  input  logic [CHAR_W-1:0] xoff2_char,
  input  logic              tx_busy,
  output logic              tx_enable,
  output logic              spec_irq,
  output logic              rx_push,
  output logic [CHAR_W-1:0] rx_push_data
);
  logic rst_int_n;
  logic fc_active, use_set1, use_set2, spec_active;
  logic [NUM_CMP-1:0][CHAR_W-1:0] cmp_chars;
  hit_t hit;

  logic              keep;
  logic              push_q, push_d;
  logic [CHAR_W-1:0] data_q, data_d;
  logic              irq_q, irq_d;

  xfc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  xfc_mode_decode u_mode (
    .enh_en      (enh_en),
    .rx_fc_mode  (rx_fc_mode),
    .tx_fc_mode  (tx_fc_mode),
    .nine_bit    (nine_bit),
    .spec_det_en (spec_det_en),
    .fc_active   (fc_active),
    .use_set1    (use_set1),
    .use_set2    (use_set2),
    .spec_active (spec_active)
  );

  always_comb begin
    cmp_chars            = '0;
    cmp_chars[IDX_XON1]  = xon1_char;
    cmp_chars[IDX_XON2]  = xon2_char;
    cmp_chars[IDX_XOFF1] = xoff1_char;
    cmp_chars[IDX_XOFF2] = xoff2_char;
  end

  xfc_char_match #(.CHAR_W(CHAR_W)) u_match (
    .rx_char     (rx_char),
    .cmp_chars   (cmp_chars),
    .use_set1    (use_set1),
    .use_set2    (use_set2),
    .spec_active (spec_active),
    .hit         (hit)
  );

  xfc_tx_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .char_stb  (rx_valid),
    .fc_active (fc_active),
    .xon_hit   (hit.xon),
    .xoff_hit  (hit.xoff),
    .tx_busy   (tx_busy),
    .tx_enable (tx_enable)
  );

  // consumed flow codes are dropped unless the special path claims them
  always_comb begin
    keep   = !(hit.xon || hit.xoff) || hit.spec;
    push_d = rx_valid && keep;
    data_d = rx_valid ? rx_char : data_q;
    irq_d  = irq_q;
    if (rx_valid && hit.spec && spec_irq_en) irq_d = 1'b1;
    else if (spec_irq_ack)                   irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      push_q <= 1'b0;
      data_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      push_q <= push_d;
      if (rx_valid) data_q <= data_d;
      irq_q  <= irq_d;
    end
  end

  assign rx_push      = push_q;
  assign rx_push_data = data_q;
  assign spec_irq     = irq_q;
endmodule

// File: rtl/xfc_checker.sv
module xfc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic       enh_en,
  input logic       nine_bit,
  input logic [1:0] rx_fc_mode,
  input logic       spec_irq_en,
  input logic       spec_irq_ack,
  input logic       tx_busy,
  input logic       tx_enable,
  input logic       spec_irq,
  input logic       rx_push
);
  // R8: an open gate never closes while a character is in flight
  a_r8_no_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_enable && tx_busy) |=> tx_enable);

  a_r6_enh_off_open: assert property (@(posedge clk) disable iff (!rst_n)
    !enh_en |=> tx_enable);

  a_r7_nine_bit_open: assert property (@(posedge clk) disable iff (!rst_n)
    nine_bit |=> tx_enable);

  a_r10_mode_off_open: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fc_mode == 2'b00) |=> tx_enable);

  a_r9_no_push_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !rx_push);

  a_r12_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (!spec_irq && !(rx_valid && spec_irq_en)) |=> !spec_irq);

  a_r11_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_irq && !spec_irq_ack) |=> spec_irq);
endmodule

bind xonoff_rx_flow xfc_checker u_xfc_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_valid     (rx_valid),
  .enh_en       (enh_en),
  .nine_bit     (nine_bit),
  .rx_fc_mode   (rx_fc_mode),
  .spec_irq_en  (spec_irq_en),
  .spec_irq_ack (spec_irq_ack),
  .tx_busy      (tx_busy),
  .tx_enable    (tx_enable),
  .spec_irq     (spec_irq),
  .rx_push      (rx_push)
);

// File: tb/test_xonoff_rx_flow.sv
module test_xonoff_rx_flow;
  localparam int CW = 8;
  localparam logic [CW-1:0] C_XON1 = 8'h11, C_XOFF1 = 8'h13;
  localparam logic [CW-1:0] C_XON2 = 8'h91, C_XOFF2 = 8'h93;
  localparam logic [CW-1:0] C_DATA = 8'h41;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [CW-1:0] rx_char = '0;
  logic enh_en = 1'b0, spec_det_en = 1'b0, nine_bit = 1'b0;
  logic spec_irq_en = 1'b0, spec_irq_ack = 1'b0, tx_busy = 1'b0;
  logic [1:0] rx_fc_mode = 2'b00, tx_fc_mode = 2'b00;
  logic tx_enable, spec_irq, rx_push;
  logic [CW-1:0] rx_push_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xonoff_rx_flow #(.CHAR_W(CW)) i_xonoff_rx_flow (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
    .enh_en(enh_en), .rx_fc_mode(rx_fc_mode), .tx_fc_mode(tx_fc_mode),
    .spec_det_en(spec_det_en), .nine_bit(nine_bit), .spec_irq_en(spec_irq_en),
    .spec_irq_ack(spec_irq_ack), .xon1_char(C_XON1), .xon2_char(C_XON2),
    .xoff1_char(C_XOFF1), .xoff2_char(C_XOFF2), .tx_busy(tx_busy),
    .tx_enable(tx_enable), .spec_irq(spec_irq), .rx_push(rx_push),
    .rx_push_data(rx_push_data)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // send one character; check the push one cycle later and the gate one cycle after that
  task automatic send(input logic [CW-1:0] c, input bit exp_push, input bit exp_tx, input string what);
    @(negedge clk); rx_valid = 1'b1; rx_char = c;
    @(negedge clk); rx_valid = 1'b0;
    check({31'd0, rx_push}, {31'd0, exp_push}, {what, " push"});
    if (exp_push) check({24'd0, rx_push_data}, {24'd0, c}, {what, " data"});
    @(negedge clk);
    check({31'd0, rx_push}, 32'd0, {what, " push is one cycle"});
    check({31'd0, tx_enable}, {31'd0, exp_tx}, {what, " gate"});
  endtask

  task automatic set_mode(input bit enh, input logic [1:0] rxm, input logic [1:0] txm);
    @(negedge clk); enh_en = enh; rx_fc_mode = rxm; tx_fc_mode = txm;
    @(negedge clk);
  endtask

  task automatic clear_state();
    set_mode(1'b1, 2'b00, 2'b00);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check({31'd0, tx_enable}, 32'd1, "R1 gate open after reset");
    check({31'd0, spec_irq}, 32'd0, "R1 irq clear after reset");
    check({31'd0, rx_push}, 32'd0, "R1 no push after reset");
  endtask

  task automatic t_set1();
    set_mode(1'b1, 2'b10, 2'b10);
    send(C_XOFF2, 1'b1, 1'b1, "R2 second-pair pause ignored");
    send(C_XOFF1, 1'b0, 1'b0, "R2/R9 first pause closes, not pushed");
    send(C_DATA,  1'b1, 1'b0, "R9 plain char pushed, state unchanged");
    send(C_XON2,  1'b1, 1'b0, "R2 second-pair resume ignored");
    send(C_XON1,  1'b0, 1'b1, "R2 first resume opens");
    clear_state();
  endtask

  task automatic t_set2();
    set_mode(1'b1, 2'b01, 2'b01);
    send(C_XOFF1, 1'b1, 1'b1, "R3 first-pair pause ignored");
    send(C_XOFF2, 1'b0, 1'b0, "R3 second pause closes");
    send(C_XON1,  1'b1, 1'b0, "R3 first-pair resume ignored");
    send(C_XON2,  1'b0, 1'b1, "R3 second resume opens");
    clear_state();
  endtask

  task automatic t_either();
    set_mode(1'b1, 2'b11, 2'b01);
    send(C_XOFF1, 1'b0, 1'b0, "R4 pause 1 closes");
    send(C_XON2,  1'b0, 1'b1, "R4 resume 2 opens");
    send(C_XOFF2, 1'b0, 1'b0, "R4 pause 2 closes");
    send(C_XON1,  1'b0, 1'b1, "R4 resume 1 opens");
    clear_state();
  endtask

  task automatic t_unsupported();
    set_mode(1'b1, 2'b11, 2'b00);
    send(C_XOFF1, 1'b1, 1'b1, "R5 mode 11 without tx mode disabled");
    clear_state();
  endtask

  task automatic t_enh_off();
    set_mode(1'b0, 2'b10, 2'b10);
    send(C_XOFF1, 1'b1, 1'b1, "R6 enhanced off ignores mode");
    clear_state();
  endtask

  task automatic t_nine_bit();
    @(negedge clk); nine_bit = 1'b1;
    set_mode(1'b1, 2'b10, 2'b10);
    send(C_XOFF1, 1'b1, 1'b1, "R7 9-bit mode disables flow control");
    @(negedge clk); nine_bit = 1'b0;
    clear_state();
  endtask

  task automatic t_busy();
    set_mode(1'b1, 2'b10, 2'b10);
    @(negedge clk); tx_busy = 1'b1;
    send(C_XOFF1, 1'b0, 1'b1, "R8 gate held during char");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check({31'd0, tx_enable}, 32'd1, "R8 gate still open while busy");
    end
    tx_busy = 1'b0;
    @(negedge clk);
    check({31'd0, tx_enable}, 32'd0, "R8 gate closes after char ends");
    send(C_XON1, 1'b0, 1'b1, "R8 resume after halt");
    clear_state();
  endtask

  task automatic t_disable();
    set_mode(1'b1, 2'b10, 2'b10);
    send(C_XOFF1, 1'b0, 1'b0, "R10 closed before disable");
    @(negedge clk); rx_fc_mode = 2'b00;
    @(negedge clk);
    check({31'd0, tx_enable}, 32'd1, "R10 mode off opens next cycle");
    rx_fc_mode = 2'b10;
    @(negedge clk); @(negedge clk);
    check({31'd0, tx_enable}, 32'd1, "R10 pause state cleared");
    clear_state();
  endtask

  task automatic t_special();
    @(negedge clk); spec_det_en = 1'b1; spec_irq_en = 1'b1;
    set_mode(1'b1, 2'b00, 2'b00);
    send(C_DATA, 1'b1, 1'b1, "R11 plain char");
    check({31'd0, spec_irq}, 32'd0, "R11 plain char no irq");
    send(C_XOFF2, 1'b1, 1'b1, "R11 special char pushed");
    check({31'd0, spec_irq}, 32'd1, "R11 special char raises irq");
    @(negedge clk); @(negedge clk);
    check({31'd0, spec_irq}, 32'd1, "R11 irq held until ack");
    spec_irq_ack = 1'b1;
    @(negedge clk); spec_irq_ack = 1'b0;
    check({31'd0, spec_irq}, 32'd0, "R11 ack clears irq");
    spec_irq_en = 1'b0;
    send(C_XOFF2, 1'b1, 1'b1, "R12 special char pushed without enable");
    check({31'd0, spec_irq}, 32'd0, "R12 no irq without enable");
    spec_det_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_set1();
    t_set2();
    t_either();
    t_unsupported();
    t_enh_off();
    t_nine_bit();
    t_busy();
    t_disable();
    t_special();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule